// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the instruction front end of a serial flash device that handles whole-array erase. It watches a mode-0 SPI link (chip select, serial clock and data input) by sampling all three with the system clock. It shifts in 8-bit opcodes and acts on three of them: one that arms writes, one that streams the status byte out, and the whole-array erase. It holds the write-arm flag, the busy flag and three protection bits. The protection bits are loaded from a test port.

An erase instruction is committed only when chip select goes high exactly after the eighth opcode bit, the write-arm flag is set and every protection bit is clear. Once committed, a timer counts a fixed number of system clock cycles and the busy flag stays high for that time. An attached memory model walks every address and writes FFh into it. The write-arm flag drops on the last tick of the timer. The busy flag falls one cycle later, together with a one-cycle done pulse. While the block is busy, status reads still work, so the host can poll. Every other instruction and every protection load is dropped during that time.

Top module: `serial_flash_erase_ctl`

## Requirements
- R1: An 8-bit transfer of opcode 06h, with chip select rising right after the eighth bit, sets the write-arm flag (`wel` goes to 1).
- R2: After opcode 05h, the status byte is shifted out MSB first on `spi_miso`, one bit per serial clock period. It changes after falling clock edges and repeats every 8 clocks while chip select stays low. Its layout is bit 0 = busy, bit 1 = write-arm, bits 4:2 = protection bits 2..0, and bits 7:5 = 0. `spi_miso` is 0 while chip select is high.
- R3: Opcodes C7h and 60h both start an erase when the write-arm flag is 1 and all protection bits are 0.
- R4: An instruction whose chip select rises after any bit count other than exactly 8 (for example 7 or 9) has no effect. No erase starts and the write-arm flag keeps its value.
- R5: When any protection bit is 1, an erase opcode is ignored. Busy stays 0 and the write-arm flag stays 1.
- R6: Busy rises on the second clock edge after chip select is sampled high and stays high for exactly ERASE_CYCLES cycles. `erase_done` pulses for one cycle in the cycle where busy first reads 0.
- R7: The write-arm flag falls while busy is still 1, exactly one cycle before busy falls.
- R8: After an erase completes, every memory byte reads FFh, whatever it held before.
- R9: While busy is 1, only status reads are served. Erase and write-arm opcodes and protection loads are ignored, and the cycle length does not change.
- R10: An erase opcode that arrives while the write-arm flag is 0 is ignored.
- R11: After reset, busy, write-arm, `erase_done` and `spi_miso` are 0, and the status byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0, sampled by clk |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial status data out |
| prot_load | input | 1 | Loads prot_value into the protection bits (test port) |
| prot_value | input | 3 | Protection bits to load; bit 2 is the top one |
| tst_wr_en | input | 1 | Memory model write strobe (test port) |
| tst_wr_addr | input | $clog2(MEM_DEPTH) | Memory model write address |
| tst_wr_data | input | 8 | Memory model write data |
| tst_rd_addr | input | $clog2(MEM_DEPTH) | Memory model read address |
| tst_rd_data | output | 8 | Memory model read data, one cycle after the address |
| wip | output | 1 | Busy flag, high for the erase cycle |
| wel | output | 1 | Write-arm flag |
| erase_done | output | 1 | One-cycle pulse when the erase cycle ends |

## Verification
The erase opcodes are tried when chip select rises after 7, 8 and 9 bits. This separates the exact-boundary commit rule from simple opcode matching. Every non-zero protection pattern is tried in turn to confirm that no single bit is left out of the protection gate. The status readback with each of those patterns also shows that the fields sit in their bit positions. Both erase opcodes run a full timed cycle, measured cycle by cycle, which checks the order of the write-arm flag drop, the busy fall and the done pulse. The second run injects a status poll, a further erase opcode and a protection load while busy, which separates polling that works from commands that leak through. Memory is filled with a non-FFh pattern before each erase and swept afterwards.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;

  localparam int BYTE_W = 8;
  localparam int BP_W   = 3;

  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_CE_A = 8'hC7;
  localparam logic [BYTE_W-1:0] OP_CE_B = 8'h60;
  localparam int N_CE_OPS = 2;

  // Matches any of the whole-array erase opcodes.
  function automatic logic is_chip_erase(input logic [BYTE_W-1:0] op);
    logic [BYTE_W-1:0] codes [N_CE_OPS];
    logic hit;
    codes[0] = OP_CE_A;
    codes[1] = OP_CE_B;
    hit = 1'b0;
    for (int i = 0; i < N_CE_OPS; i++) begin
      if (op == codes[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  // Status layout: [0] busy, [1] write-arm, [BP_W+1:2] protection, rest zero.
  function automatic logic [BYTE_W-1:0] build_status(input logic [BP_W-1:0] bp,
                                                     input logic wel,
                                                     input logic wip);
    return {{(BYTE_W-BP_W-2){1'b0}}, bp, wel, wip};
  endfunction

endpackage

// File: rtl/sfe_spi_front.sv
`timescale 1ns/1ps
module sfe_spi_front
  import sfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] status,
  output logic              miso,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_code
);

  localparam int CNT_W = $clog2(2*BYTE_W);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2*BYTE_W-1);

  logic              cs_q;
  logic              sck_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] op_sr;
  logic [BYTE_W-1:0] out_sr;
  logic              sck_rise;
  logic              sck_fall;
  logic              rd_mode;

  assign sck_rise = ~cs_n & sck & ~sck_q;
  assign sck_fall = ~cs_n & ~sck & sck_q;
  assign rd_mode  = (bit_cnt >= CNT_BYTE) && (op_sr == OP_RDSR);
  assign miso     = out_sr[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
      bit_cnt   <= '0;
      op_sr     <= '0;
      out_sr    <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      cs_q      <= cs_n;
      sck_q     <= sck;
      cmd_valid <= 1'b0;
      if (cs_n) begin
        bit_cnt <= '0;
        out_sr  <= '0;
        // Commit only when the select edge lands on the byte boundary.
        if (!cs_q && (bit_cnt == CNT_BYTE)) begin
          cmd_valid <= 1'b1;
          cmd_code  <= op_sr;
        end
      end else begin
        if (sck_rise) begin
          if (bit_cnt < CNT_BYTE) op_sr <= {op_sr[BYTE_W-2:0], mosi};
          if (rd_mode && (bit_cnt == CNT_LAST)) bit_cnt <= CNT_BYTE;
          else if (bit_cnt != CNT_LAST)         bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall) begin
          if (rd_mode && (bit_cnt == CNT_BYTE)) out_sr <= status;
          else                                  out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/sfe_cmd_regs.sv
`timescale 1ns/1ps
module sfe_cmd_regs
  import sfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_code,
  input  logic              prot_load,
  input  logic [BP_W-1:0]   prot_value,
  input  logic              wip,
  input  logic              wel_clr,
  output logic              wel,
  output logic [BP_W-1:0]   bp,
  output logic              erase_start
);

  logic cmd_is_ce;
  logic cmd_is_wren;
  logic unprotected;

  assign cmd_is_ce   = is_chip_erase(cmd_code);
  assign cmd_is_wren = (cmd_code == OP_WREN);
  assign unprotected = (bp == '0);
  assign erase_start = cmd_valid && !wip && cmd_is_ce && wel && unprotected;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0;
      bp  <= '0;
    end else begin
      if (wel_clr)                             wel <= 1'b0;
      else if (cmd_valid && !wip && cmd_is_wren) wel <= 1'b1;
      if (prot_load && !wip) bp <= prot_value;
    end
  end

endmodule

// File: rtl/sfe_erase_timer.sv
`timescale 1ns/1ps
module sfe_erase_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic wip,
  output logic wel_clr,
  output logic done
);

  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES-1);

  logic [CW-1:0] cnt;

  // Last tick: write-arm drops here, busy falls on the following edge.
  assign wel_clr = wip && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wip  <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !wip) begin
        wip <= 1'b1;
        cnt <= LOAD;
      end else if (wip) begin
        if (cnt == '0) begin
          wip  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sfe_mem_array.sv
`timescale 1ns/1ps
module sfe_mem_array #(
  parameter int DEPTH = 256,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wipe_start,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [W-1:0]             rd_data
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic          wipe_on;
  logic [AW-1:0] wipe_addr;
  logic          we;
  logic [AW-1:0] waddr;
  logic [W-1:0]  wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      wipe_on   <= 1'b0;
      wipe_addr <= '0;
    end else if (wipe_start) begin
      wipe_on   <= 1'b1;
      wipe_addr <= '0;
    end else if (wipe_on) begin
      if (wipe_addr == LAST) wipe_on <= 1'b0;
      else                   wipe_addr <= wipe_addr + 1'b1;
    end
  end

  // One write port shared by the wipe walker and the test port.
  always_comb begin
    we    = wipe_on | wr_en;
    waddr = wipe_on ? wipe_addr : wr_addr;
    wdata = wipe_on ? {W{1'b1}} : wr_data;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/serial_flash_erase_ctl.sv
`timescale 1ns/1ps
module serial_flash_erase_ctl
  import sfe_pkg::*;
#(
  parameter int MEM_DEPTH    = 256,
  parameter int ERASE_CYCLES = 1000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         spi_cs_n,
  input  logic                         spi_sck,
  input  logic                         spi_mosi,
  output logic                         spi_miso,
  input  logic                         prot_load,
  input  logic [2:0]                   prot_value,
  input  logic                         tst_wr_en,
  input  logic [$clog2(MEM_DEPTH)-1:0] tst_wr_addr,
  input  logic [7:0]                   tst_wr_data,
  input  logic [$clog2(MEM_DEPTH)-1:0] tst_rd_addr,
  output logic [7:0]                   tst_rd_data,
  output logic                         wip,
  output logic                         wel,
  output logic                         erase_done
);

  if (ERASE_CYCLES < MEM_DEPTH + 2) begin : g_len_check
    $error("ERASE_CYCLES must cover the memory wipe plus two cycles");
  end

  logic              cmd_valid;
  logic [BYTE_W-1:0] cmd_code;
  logic [BYTE_W-1:0] status;
  logic [BP_W-1:0]   bp_q;
  logic              erase_start;
  logic              wel_clr;

  assign status = build_status(bp_q, wel, wip);

  sfe_spi_front u_front (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .status    (status),
    .miso      (spi_miso),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code)
  );

  sfe_cmd_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .prot_load   (prot_load),
    .prot_value  (prot_value),
    .wip         (wip),
    .wel_clr     (wel_clr),
    .wel         (wel),
    .bp          (bp_q),
    .erase_start (erase_start)
  );

  sfe_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (erase_start),
    .wip     (wip),
    .wel_clr (wel_clr),
    .done    (erase_done)
  );

  sfe_mem_array #(.DEPTH(MEM_DEPTH), .W(BYTE_W)) u_mem (
    .clk        (clk),
    .rst        (rst),
    .wipe_start (erase_start),
    .wr_en      (tst_wr_en),
    .wr_addr    (tst_wr_addr),
    .wr_data    (tst_wr_data),
    .rd_addr    (tst_rd_addr),
    .rd_data    (tst_rd_data)
  );

endmodule

// File: rtl/serial_flash_erase_chk.sv
`timescale 1ns/1ps
module serial_flash_erase_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       miso,
  input logic       wip,
  input logic       wel,
  input logic       done,
  input logic [2:0] bp
);

  assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> ($past(wel) && ($past(bp) == 3'b000)));

  assert_boundary_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(cs_n, 2));

  assert_done_fall_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(wip));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_wel_first_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !$past(wel));

  assert_bp_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    wip |=> $stable(bp));

  assert_no_arm_busy_R9: assert property (@(posedge clk) disable iff (rst)
    wip |=> !$rose(wel));

  assert_miso_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !miso);

endmodule

bind serial_flash_erase_ctl serial_flash_erase_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .cs_n (spi_cs_n),
  .miso (spi_miso),
  .wip  (wip),
  .wel  (wel),
  .done (erase_done),
  .bp   (bp_q)
);

// File: tb/sim_serial_flash_erase_ctl.sv
`timescale 1ns/1ps
module sim_serial_flash_erase_ctl;

  localparam int DEPTH = 16;
  localparam int ECYC  = 300;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spi_cs_n = 1'b1;
  logic          spi_sck = 1'b0;
  logic          spi_mosi = 1'b0;
  logic          spi_miso;
  logic          prot_load = 1'b0;
  logic [2:0]    prot_value = 3'b000;
  logic          tst_wr_en = 1'b0;
  logic [AW-1:0] tst_wr_addr = '0;
  logic [7:0]    tst_wr_data = '0;
  logic [AW-1:0] tst_rd_addr = '0;
  logic [7:0]    tst_rd_data;
  logic          wip;
  logic          wel;
  logic          erase_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_flash_erase_ctl #(.MEM_DEPTH(DEPTH), .ERASE_CYCLES(ECYC)) u0 (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .prot_load(prot_load),
    .prot_value(prot_value), .tst_wr_en(tst_wr_en), .tst_wr_addr(tst_wr_addr),
    .tst_wr_data(tst_wr_data), .tst_rd_addr(tst_rd_addr),
    .tst_rd_data(tst_rd_data), .wip(wip), .wel(wel), .erase_done(erase_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends n bits MSB first; rx holds the last 16 miso samples.
  task automatic spi_xfer(input logic [23:0] bits, input int n, output logic [15:0] rx);
    rx = '0;
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_mosi = bits[n-1-i];
      repeat (2) @(negedge clk);
      rx = {rx[14:0], spi_miso};
      spi_sck = 1'b1;
      repeat (2) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (2) @(negedge clk);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_status(output logic [7:0] st);
    logic [15:0] rx;
    spi_xfer({8'h00, 8'h05, 8'h00}, 16, rx);
    st = rx[7:0];
    idle(4);
  endtask

  task automatic send_op(input logic [7:0] op);
    logic [15:0] rx;
    spi_xfer({16'h0, op}, 8, rx);
  endtask

  task automatic load_prot(input logic [2:0] v);
    @(negedge clk) prot_load = 1'b1; prot_value = v;
    @(negedge clk) prot_load = 1'b0;
  endtask

  task automatic mem_fill(input int seed);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      tst_wr_en = 1'b1; tst_wr_addr = AW'(a); tst_wr_data = 8'((a*13 + seed) & 8'h7F);
    end
    @(negedge clk) tst_wr_en = 1'b0;
  endtask

  task automatic mem_read(input int a, output logic [7:0] d);
    @(negedge clk) tst_rd_addr = AW'(a);
    @(negedge clk) d = tst_rd_data;
  endtask

  // Called right after chip select was raised at a falling clock edge.
  task automatic run_erase(output int cycles, output bit wel_ok, output bit done_ok);
    int c;
    logic wl_last, wl_prev;
    c = 0; wl_last = 1'b1; wl_prev = 1'b1; done_ok = 1'b1;
    @(negedge clk);
    @(negedge clk);
    while (wip && c < 5000) begin
      c++;
      if (erase_done) done_ok = 1'b0;
      wl_prev = wl_last;
      wl_last = wel;
      @(negedge clk);
    end
    cycles = c;
    wel_ok = (wl_last == 1'b0) && (wl_prev == 1'b1);
    done_ok = done_ok & erase_done;
    @(negedge clk);
    done_ok = done_ok & !erase_done;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0]  st;
    logic [7:0]  d;
    logic [15:0] rx;
    int          cyc;
    bit          wel_ok, done_ok;
    int          bad;
    logic [7:0]  st_busy;

    idle(4);
    rst = 1'b0;
    idle(2);

    // R11 reset state
    chk(!wip && !wel && !erase_done && !spi_miso, "R11 reset outputs",
        {wip, wel, erase_done, spi_miso}, 0);
    read_status(st);
    chk(st == 8'h00, "R11 R2 status after reset", st, 8'h00);

    // R4: write-arm with 7 bits does nothing
    begin logic [15:0] r7; spi_xfer({16'h0, 8'h03}, 7, r7); end
    idle(4);
    chk(wel == 1'b0, "R4 seven-bit arm ignored", wel, 0);

    // R1
    send_op(8'h06); idle(4);
    chk(wel == 1'b1, "R1 write-arm set", wel, 1);
    read_status(st);
    chk(st == 8'h02, "R2 status with arm set", st, 8'h02);

    // R2 repeat across 24 clocks
    spi_xfer({8'h05, 16'h0000}, 24, rx); idle(4);
    chk(rx == 16'h0202, "R2 status repeats each byte", rx, 16'h0202);

    // R4: erase opcode with 7 and 9 bits
    spi_xfer({16'h0, 8'h63}, 7, rx); idle(6);
    chk(!wip && wel, "R4 erase after 7 bits ignored", {wip, wel}, 1);
    spi_xfer({15'h0, 8'hC7, 1'b1}, 9, rx); idle(6);
    chk(!wip && wel, "R4 erase after 9 bits ignored", {wip, wel}, 1);

    // R5: every non-zero protection pattern blocks both erase opcodes
    for (int p = 1; p < 8; p++) begin
      load_prot(3'(p));
      read_status(st);
      chk(st == 8'((p << 2) | 2), "R2 R5 status with protection", st, (p << 2) | 2);
      send_op((p % 2) ? 8'hC7 : 8'h60); idle(6);
      chk(!wip && wel, "R5 protected erase ignored", {wip, wel}, 1);
    end
    load_prot(3'b000);
    read_status(st);
    chk(st == 8'h02, "R5 protection cleared", st, 8'h02);

    // Memory pre-fill and readback
    mem_fill(7);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      mem_read(a, d);
      if (d != 8'((a*13 + 7) & 8'h7F)) bad++;
    end
    chk(bad == 0, "R8 pre-erase pattern stored", bad, 0);

    // R3 R6 R7: erase with C7h
    send_op(8'hC7);
    run_erase(cyc, wel_ok, done_ok);
    chk(cyc == ECYC, "R3 R6 busy length C7h", cyc, ECYC);
    chk(wel_ok, "R7 arm drops one cycle before busy", wel_ok, 1);
    chk(done_ok, "R6 single done pulse", done_ok, 1);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      mem_read(a, d);
      if (d != 8'hFF) bad++;
    end
    chk(bad == 0, "R8 all bytes FFh after erase", bad, 0);
    read_status(st);
    chk(st == 8'h00, "R7 status clear after erase", st, 8'h00);

    // R10: erase without arm
    send_op(8'h60); idle(6);
    chk(!wip, "R10 erase without arm ignored", wip, 0);

    // R3 R9: second erase with 60h, traffic during busy
    mem_fill(3);
    send_op(8'h06); idle(4);
    send_op(8'h60);
    st_busy = '0;
    fork
      run_erase(cyc, wel_ok, done_ok);
      begin
        logic [15:0] rb;
        idle(10);
        spi_xfer({8'h00, 8'h05, 8'h00}, 16, rb);
        st_busy = rb[7:0];
        idle(4);
        spi_xfer({16'h0, 8'hC7}, 8, rb);
        idle(4);
        @(negedge clk) prot_load = 1'b1; prot_value = 3'b111;
        @(negedge clk) prot_load = 1'b0;
      end
    join
    chk(st_busy == 8'h03, "R9 R2 status poll while busy", st_busy, 8'h03);
    chk(cyc == ECYC, "R3 R9 busy length 60h unchanged", cyc, ECYC);
    chk(wel_ok && done_ok, "R6 R7 second run ordering", {wel_ok, done_ok}, 3);
    read_status(st);
    chk(st == 8'h00, "R9 protection load ignored while busy", st, 8'h00);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      mem_read(a, d);
      if (d != 8'hFF) bad++;
    end
    chk(bad == 0, "R8 all bytes FFh after second erase", bad, 0);

    finish_run();
  end

endmodule